// File: doc/BRIEF.md
# NAND Flash Command Interface Decoder

This block is the device-side front end of an asynchronous 8-bit NAND flash bus, brought into one clock domain. On every write strobe it looks at chip enable and the command and address latch enables. It then treats the bus byte as a command, as an address cycle, or as data, which is ignored here. It holds the opcode currently in force and assembles a byte-wise address from successive address cycles. It also keeps a small status register and drives the identification and status bytes onto the read path.

When a read, program or erase sequence is complete, the block fires a one-cycle start pulse to an external array engine. With the pulse it presents the operation address and, for reads, the column offset. The block then shows busy until the engine reports completion. A single parameter selects the small-page dialect or the large-page dialect. The small-page dialect uses read-pointer opcodes and starts a read on the last address cycle. The large-page dialect uses a two-phase read confirm and random column re-addressing.

Top module: `nand_cmd_if`

## Requirements
- R1: Strobes while `ce_n` is high are ignored, and `dout` is 0x00 while `ce_n` is high.
- R2: Address cycle k, counted from 0 since the last accepted command, writes byte k (bits 8k+7..8k) of the address register and leaves the other bytes unchanged. Cycles beyond `ADDR_CYC` are ignored.
- R3: Small-page dialect only: 0x00, 0x01 and 0x50 select read column offsets of 0, 256 and `PAGE_BYTES` respectively, and all three then act as a read. The address cycle numbered `ADDR_CYC-1` of that read raises `rd_start` together with `op_addr` and `op_offset`.
- R4: Large-page dialect: address cycles after 0x00 start nothing. A following 0x30 raises `rd_start` with the assembled address and an offset of 0.
- R5: Large-page dialect: 0x05 zeroes the two column bytes and restarts the address-cycle count. A later 0xE0 raises `rd_start` with the new column and the row bytes kept.
- R6: After 0x90, reads return 0x00 until one address cycle is written. Reads then return the manufacturer code, the device code and 0xA5, followed in the large-page dialect by 0x15 (0x55 when `BUS16`) and 0xC0. Every read after the last of these returns 0x00.
- R7: The status byte has bit 7 equal to `wp_n`, bit 6 equal to ready, bit 0 equal to error, and bits 5..1 at zero.
- R8: After 0x70, every read returns the current status byte until another command is accepted.
- R9: 0x10 after 0x80 raises `prog_start` with `op_addr` equal to the assembled address.
- R10: 0xD0 after 0x60 raises `erase_start` with `op_addr` equal to the assembled address shifted left by 8 bits per column byte (8 in the small-page dialect, 16 in the large-page one).
- R11: Each start pulse clears ready in the same cycle it appears. `eng_done` sets ready again and loads the error bit from `eng_fail`.
- R12: 0xFF sets ready, clears error and leaves a plain read (0x00) as the current command.
- R13: An opcode outside the accepted set, or a confirm that does not follow its opening opcode, leaves the command and the status unchanged.
- R14: At most one start pulse is high in any cycle, and each pulse lasts one cycle per confirming strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| we_strobe | input | 1 | One-cycle write strobe sampling `din` |
| re_strobe | input | 1 | One-cycle read strobe advancing the reply pointer |
| din | input | 8 | Bus byte written by the host |
| eng_done | input | 1 | Array engine finished the running operation |
| eng_fail | input | 1 | Engine result flag, valid with `eng_done` |
| dout | output | 8 | Reply byte (ID or status) |
| ready | output | 1 | High when no operation is running |
| rd_start | output | 1 | Read start pulse |
| prog_start | output | 1 | Program start pulse |
| erase_start | output | 1 | Erase start pulse |
| op_addr | output | 8*ADDR_CYC | Operation byte address |
| op_offset | output | $clog2(PAGE_BYTES)+1 | Read column offset (small-page dialect) |

## Verification
Two copies of the block, one in each dialect, sit on the same bus. The same byte stream therefore shows the cases where the dialects must differ: 0x01 and 0x50 move the offset in one copy and are ignored by the other, and a read starts on the last address cycle in one copy but only after 0x30 in the other. The reads use distinct address bytes in each cycle, so a swapped or misplaced lane is visible. Random column changes are tried once with two column cycles and once with one, which shows whether 0x05 really cleared the upper column byte. The status and ID paths are exercised against repeated reads, a toggled `wp_n`, an engine failure, a reset in mid-operation, unknown and out-of-order opcodes, and strobes while the chip is deselected.

// File: rtl/nand_cmd_pkg.sv
`timescale 1ns/1ps
package nand_cmd_pkg;
  localparam logic [7:0] OP_READ      = 8'h00;
  localparam logic [7:0] OP_READ_HI   = 8'h01;
  localparam logic [7:0] OP_READ_SPR  = 8'h50;
  localparam logic [7:0] OP_READ_GO   = 8'h30;
  localparam logic [7:0] OP_COL_CHG   = 8'h05;
  localparam logic [7:0] OP_COL_GO    = 8'hE0;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_RESET     = 8'hFF;
  localparam logic [7:0] OP_PROG      = 8'h80;
  localparam logic [7:0] OP_PROG_GO   = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'h60;
  localparam logic [7:0] OP_ERASE_GO  = 8'hD0;
  localparam logic [7:0] OP_STATUS    = 8'h70;

  localparam logic [7:0] ID_FILLER    = 8'hA5;
  localparam logic [7:0] ID_GEOM_X8   = 8'h15;
  localparam logic [7:0] ID_GEOM_X16  = 8'h55;
  localparam logic [7:0] ID_PLANES    = 8'hC0;

  function automatic logic op_known(input logic [7:0] b);
    return b inside {OP_READ, OP_READ_HI, OP_READ_SPR, OP_READ_GO, OP_COL_CHG,
                     OP_COL_GO, OP_IDENT, OP_RESET, OP_PROG, OP_PROG_GO,
                     OP_ERASE, OP_ERASE_GO, OP_STATUS};
  endfunction
endpackage

// File: rtl/nand_addr_asm.sv
`timescale 1ns/1ps
module nand_addr_asm #(
  parameter int CYC     = 3,
  parameter int COL_CYC = 1,
  localparam int AW     = 8 * CYC,
  localparam int CW     = $clog2(CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_we,
  input  logic [7:0]    din,
  input  logic          clr_cnt,
  input  logic          clr_col,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] addr_nx,
  output logic          last
);
  logic [CYC-1:0][7:0] lane_q, lane_d;
  logic [CW-1:0]       cnt_q, cnt_d;

  // one lane per address cycle; column lanes can be cleared
  for (genvar g = 0; g < CYC; g++) begin : g_lane
    if (g < COL_CYC) begin : g_col
      assign lane_d[g] = (byte_we && cnt_q == CW'(g)) ? din :
                         clr_col ? 8'h00 : lane_q[g];
    end else begin : g_row
      assign lane_d[g] = (byte_we && cnt_q == CW'(g)) ? din : lane_q[g];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr_cnt)
      cnt_d = '0;
    else if (byte_we && cnt_q < CW'(CYC))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      cnt_q  <= '0;
    end else begin
      lane_q <= lane_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr_q  = lane_q;
  assign addr_nx = lane_d;
  assign last    = byte_we && (cnt_q == CW'(CYC - 1));
endmodule

// File: rtl/nand_status_reg.sv
`timescale 1ns/1ps
module nand_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       done,
  input  logic       fail,
  input  logic       soft_rst,
  input  logic       wp_n,
  output logic       ready,
  output logic [7:0] status
);
  logic rdy_q, rdy_d, err_q, err_d;

  always_comb begin
    rdy_d = rdy_q;
    err_d = err_q;
    if (soft_rst) begin
      rdy_d = 1'b1;
      err_d = 1'b0;
    end else if (start) begin
      rdy_d = 1'b0;
    end else if (done) begin
      rdy_d = 1'b1;
      err_d = fail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b1;
      err_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      err_q <= err_d;
    end
  end

  assign ready  = rdy_q;
  assign status = {wp_n, rdy_q, 5'b00000, err_q};
endmodule

// File: rtl/nand_reply_mux.sv
`timescale 1ns/1ps
module nand_reply_mux
  import nand_cmd_pkg::*;
#(
  parameter bit         LARGE_PAGE = 1'b0,
  parameter bit         BUS16      = 1'b0,
  parameter logic [7:0] MFR_CODE   = 8'hEC,
  parameter logic [7:0] DEV_CODE   = 8'h73,
  localparam int        ID_LEN     = LARGE_PAGE ? 5 : 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cmd_id,
  input  logic       cmd_stat,
  input  logic       id_arm,
  input  logic       clr,
  input  logic       rd_adv,
  input  logic [7:0] status,
  output logic [7:0] dout
);
  logic [7:0] id_tab [5];
  logic       arm_q, arm_d;
  logic [2:0] ptr_q, ptr_d;

  assign id_tab[0] = MFR_CODE;
  assign id_tab[1] = DEV_CODE;
  assign id_tab[2] = ID_FILLER;
  if (LARGE_PAGE) begin : g_lp_id
    assign id_tab[3] = BUS16 ? ID_GEOM_X16 : ID_GEOM_X8;
    assign id_tab[4] = ID_PLANES;
  end else begin : g_sp_id
    assign id_tab[3] = 8'h00;
    assign id_tab[4] = 8'h00;
  end

  always_comb begin
    arm_d = arm_q;
    ptr_d = ptr_q;
    if (clr) begin
      arm_d = 1'b0;
      ptr_d = '0;
    end else if (id_arm) begin
      arm_d = 1'b1;
      ptr_d = '0;
    end else if (rd_adv && cmd_id && arm_q && ptr_q < 3'(ID_LEN)) begin
      ptr_d = ptr_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      arm_q <= arm_d;
      ptr_q <= ptr_d;
    end
  end

  always_comb begin
    dout = 8'h00;
    if (!ce_n) begin
      if (cmd_stat)
        dout = status;
      else if (cmd_id && arm_q && ptr_q < 3'(ID_LEN))
        dout = id_tab[ptr_q];
    end
  end
endmodule

// File: rtl/nand_cmd_if.sv
`timescale 1ns/1ps
module nand_cmd_if
  import nand_cmd_pkg::*;
#(
  parameter bit         LARGE_PAGE = 1'b0,
  parameter bit         BUS16      = 1'b0,
  parameter int         ADDR_CYC   = 3,
  parameter int         PAGE_BYTES = 512,
  parameter logic [7:0] MFR_CODE   = 8'hEC,
  parameter logic [7:0] DEV_CODE   = 8'h73,
  localparam int        AW         = 8 * ADDR_CYC,
  localparam int        OFS_W      = $clog2(PAGE_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             wp_n,
  input  logic             we_strobe,
  input  logic             re_strobe,
  input  logic [7:0]       din,
  input  logic             eng_done,
  input  logic             eng_fail,
  output logic [7:0]       dout,
  output logic             ready,
  output logic             rd_start,
  output logic             prog_start,
  output logic             erase_start,
  output logic [AW-1:0]    op_addr,
  output logic [OFS_W-1:0] op_offset
);
  localparam int COL_CYC = LARGE_PAGE ? 2 : 1;
  localparam int ROW_SH  = 8 * COL_CYC;

  logic       cmd_we, adr_we;
  logic [7:0] cmd_q, cmd_d;
  logic       is_read, is_hi, is_spare, is_rd_go, is_col, is_col_go;
  logic       is_id, is_rst, is_prog, is_prog_go, is_erase, is_erase_go, is_stat;
  logic       accept;
  logic       rd_go, prg_go, ers_go, any_go;
  logic [AW-1:0] addr_q, addr_nx;
  logic       addr_last;
  logic [OFS_W-1:0] ofs_q;
  logic [7:0] status_b;
  logic       rd_q, prg_q, ers_q;
  logic [AW-1:0]    op_addr_q, op_addr_d;
  logic [OFS_W-1:0] op_ofs_q, op_ofs_d;

  // bus cycle classification
  assign cmd_we = we_strobe && !ce_n && cle;
  assign adr_we = we_strobe && !ce_n && !cle && ale;

  // opcode decode, dialect gated
  always_comb begin
    is_read     = (din == OP_READ);
    is_hi       = !LARGE_PAGE && (din == OP_READ_HI);
    is_spare    = !LARGE_PAGE && (din == OP_READ_SPR);
    is_rd_go    = LARGE_PAGE && (din == OP_READ_GO) && (cmd_q == OP_READ);
    is_col      = LARGE_PAGE && (din == OP_COL_CHG);
    is_col_go   = LARGE_PAGE && (din == OP_COL_GO) && (cmd_q == OP_COL_CHG);
    is_id       = (din == OP_IDENT);
    is_rst      = (din == OP_RESET);
    is_prog     = (din == OP_PROG);
    is_prog_go  = (din == OP_PROG_GO) && (cmd_q == OP_PROG);
    is_erase    = (din == OP_ERASE);
    is_erase_go = (din == OP_ERASE_GO) && (cmd_q == OP_ERASE);
    is_stat     = (din == OP_STATUS);
  end

  assign accept = cmd_we && (is_read || is_hi || is_spare || is_rd_go || is_col ||
                  is_col_go || is_id || is_rst || is_prog || is_prog_go ||
                  is_erase || is_erase_go || is_stat);

  always_comb begin
    cmd_d = cmd_q;
    if (accept)
      cmd_d = (is_hi || is_spare || is_rst) ? OP_READ : din;
  end

  // start conditions
  if (LARGE_PAGE) begin : g_lp_rd
    assign rd_go = cmd_we && (is_rd_go || is_col_go);
  end else begin : g_sp_rd
    assign rd_go = adr_we && (cmd_q == OP_READ) && addr_last;
  end
  assign prg_go = cmd_we && is_prog_go;
  assign ers_go = cmd_we && is_erase_go;
  assign any_go = rd_go || prg_go || ers_go;

  // read column offset register, small-page dialect only
  if (LARGE_PAGE) begin : g_lp_ofs
    assign ofs_q = '0;
  end else begin : g_sp_ofs
    logic [OFS_W-1:0] ofs_r, ofs_d;
    always_comb begin
      ofs_d = ofs_r;
      if (cmd_we && (is_read || is_rst)) ofs_d = '0;
      else if (cmd_we && is_hi)          ofs_d = OFS_W'(256);
      else if (cmd_we && is_spare)       ofs_d = OFS_W'(PAGE_BYTES);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ofs_r <= '0;
      else        ofs_r <= ofs_d;
    end
    assign ofs_q = ofs_r;
  end

  nand_addr_asm #(.CYC(ADDR_CYC), .COL_CYC(COL_CYC)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (adr_we),
    .din     (din),
    .clr_cnt (accept),
    .clr_col (cmd_we && is_col),
    .addr_q  (addr_q),
    .addr_nx (addr_nx),
    .last    (addr_last)
  );

  nand_status_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (any_go),
    .done     (eng_done),
    .fail     (eng_fail),
    .soft_rst (cmd_we && is_rst),
    .wp_n     (wp_n),
    .ready    (ready),
    .status   (status_b)
  );

  nand_reply_mux #(
    .LARGE_PAGE (LARGE_PAGE),
    .BUS16      (BUS16),
    .MFR_CODE   (MFR_CODE),
    .DEV_CODE   (DEV_CODE)
  ) u_reply (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .cmd_id   (cmd_q == OP_IDENT),
    .cmd_stat (cmd_q == OP_STATUS),
    .id_arm   (adr_we && cmd_q == OP_IDENT),
    .clr      (accept),
    .rd_adv   (re_strobe && !ce_n),
    .status   (status_b),
    .dout     (dout)
  );

  // operation descriptor
  always_comb begin
    op_addr_d = op_addr_q;
    op_ofs_d  = op_ofs_q;
    if (ers_go) begin
      op_addr_d = addr_nx << ROW_SH;
      op_ofs_d  = '0;
    end else if (rd_go) begin
      op_addr_d = addr_nx;
      op_ofs_d  = ofs_q;
    end else if (prg_go) begin
      op_addr_d = addr_nx;
      op_ofs_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= OP_READ;
      rd_q      <= 1'b0;
      prg_q     <= 1'b0;
      ers_q     <= 1'b0;
      op_addr_q <= '0;
      op_ofs_q  <= '0;
    end else begin
      cmd_q <= cmd_d;
      rd_q  <= rd_go;
      prg_q <= prg_go;
      ers_q <= ers_go;
      if (any_go) begin
        op_addr_q <= op_addr_d;
        op_ofs_q  <= op_ofs_d;
      end
    end
  end

  assign rd_start    = rd_q;
  assign prog_start  = prg_q;
  assign erase_start = ers_q;
  assign op_addr     = op_addr_q;
  assign op_offset   = op_ofs_q;
endmodule

// File: rtl/nand_cmd_if_chk.sv
`timescale 1ns/1ps
module nand_cmd_if_chk
  import nand_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       cle,
  input logic       we_strobe,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       ready,
  input logic       rd_start,
  input logic       prog_start,
  input logic       erase_start,
  input logic       eng_done,
  input logic [7:0] cmd_q,
  input logic [7:0] status
);
  p_ce_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> dout == 8'h00);

  p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && cmd_q == OP_STATUS) |-> dout == status);

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start || prog_start || erase_start) |-> !ready);

  p_one_start_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_start, prog_start, erase_start}));

  p_unknown_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (we_strobe && !ce_n && cle && !op_known(din)) |=> $stable(cmd_q));

  p_unknown_stat_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (we_strobe && !ce_n && cle && !op_known(din) && !eng_done) |=> $stable(status[6:0]));

  p_ready_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] == ready);
endmodule

bind nand_cmd_if nand_cmd_if_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce_n        (ce_n),
  .cle         (cle),
  .we_strobe   (we_strobe),
  .din         (din),
  .dout        (dout),
  .ready       (ready),
  .rd_start    (rd_start),
  .prog_start  (prog_start),
  .erase_start (erase_start),
  .eng_done    (eng_done),
  .cmd_q       (cmd_q),
  .status      (status_b)
);

// File: tb/nand_cmd_if_bench.sv
`timescale 1ns/1ps
module nand_cmd_if_bench;
  logic clk = 1'b0;
  logic rst_n, ce_n, cle, ale, wp_n, we_strobe, re_strobe, eng_done, eng_fail;
  logic [7:0] din;

  logic [7:0]  dout_sp, dout_lp;
  logic        rdy_sp, rdy_lp, rd_sp, rd_lp, pg_sp, pg_lp, er_sp, er_lp;
  logic [23:0] oa_sp;
  logic [39:0] oa_lp;
  logic [9:0]  of_sp, of_lp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nand_cmd_if u_nand_cmd_if (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .we_strobe(we_strobe), .re_strobe(re_strobe), .din(din),
    .eng_done(eng_done), .eng_fail(eng_fail), .dout(dout_sp), .ready(rdy_sp),
    .rd_start(rd_sp), .prog_start(pg_sp), .erase_start(er_sp),
    .op_addr(oa_sp), .op_offset(of_sp));

  nand_cmd_if #(.LARGE_PAGE(1'b1), .ADDR_CYC(5), .PAGE_BYTES(512),
                .MFR_CODE(8'h2C), .DEV_CODE(8'hF1)) u_nand_cmd_if_lp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .we_strobe(we_strobe), .re_strobe(re_strobe), .din(din),
    .eng_done(eng_done), .eng_fail(eng_fail), .dout(dout_lp), .ready(rdy_lp),
    .rd_start(rd_lp), .prog_start(pg_lp), .erase_start(er_lp),
    .op_addr(oa_lp), .op_offset(of_lp));

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic put_cmd(input logic [7:0] b);
    @(negedge clk); cle = 1'b1; ale = 1'b0; din = b; we_strobe = 1'b1;
    @(negedge clk); we_strobe = 1'b0; cle = 1'b0;
  endtask

  task automatic put_addr(input logic [7:0] b);
    @(negedge clk); cle = 1'b0; ale = 1'b1; din = b; we_strobe = 1'b1;
    @(negedge clk); we_strobe = 1'b0; ale = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] vs, output logic [7:0] vl);
    @(negedge clk); vs = dout_sp; vl = dout_lp; re_strobe = 1'b1;
    @(negedge clk); re_strobe = 1'b0;
  endtask

  task automatic finish_op(input logic fail);
    @(negedge clk); eng_done = 1'b1; eng_fail = fail;
    @(negedge clk); eng_done = 1'b0; eng_fail = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R12 ready after reset sp", rdy_sp, 1);
    chk("R12 ready after reset lp", rdy_lp, 1);
    chk("R12 dout idle read sp", dout_sp, 8'h00);
    put_cmd(8'h70);
    chk("R7 status after reset sp", dout_sp, 8'hC0);
    chk("R7 status after reset lp", dout_lp, 8'hC0);
  endtask

  task automatic t_status_sticky;
    logic [7:0] a, b;
    for (int i = 0; i < 3; i++) begin
      get_byte(a, b);
      chk("R8 repeated status sp", a, 8'hC0);
      chk("R8 repeated status lp", b, 8'hC0);
    end
    wp_n = 1'b0;
    @(negedge clk);
    chk("R7 wp bit low", dout_sp, 8'h40);
    wp_n = 1'b1;
    @(negedge clk);
    chk("R7 wp bit high", dout_sp, 8'hC0);
  endtask

  task automatic t_ce_gate;
    ce_n = 1'b1;
    @(negedge clk);
    chk("R1 dout deselected", dout_sp, 8'h00);
    put_cmd(8'h90);
    ce_n = 1'b0;
    @(negedge clk);
    chk("R1 command ignored while deselected", dout_sp, 8'hC0);
  endtask

  task automatic t_unknown;
    put_cmd(8'h42);
    chk("R13 unknown opcode keeps status sp", dout_sp, 8'hC0);
    chk("R13 unknown opcode keeps status lp", dout_lp, 8'hC0);
    put_cmd(8'h10);
    chk("R13 stray confirm ignored", dout_sp, 8'hC0);
    chk("R13 stray confirm no start", pg_sp, 0);
  endtask

  task automatic t_read_id;
    logic [7:0] es [6] = '{8'hEC, 8'h73, 8'hA5, 8'h00, 8'h00, 8'h00};
    logic [7:0] el [6] = '{8'h2C, 8'hF1, 8'hA5, 8'h15, 8'hC0, 8'h00};
    logic [7:0] a, b;
    put_cmd(8'h90);
    chk("R6 no reply before address sp", dout_sp, 8'h00);
    chk("R6 no reply before address lp", dout_lp, 8'h00);
    put_addr(8'h00);
    for (int i = 0; i < 6; i++) begin
      get_byte(a, b);
      chk($sformatf("R6 id byte %0d sp", i), a, es[i]);
      chk($sformatf("R6 id byte %0d lp", i), b, el[i]);
    end
  endtask

  task automatic t_small_reads;
    put_cmd(8'h00);
    put_addr(8'h12);
    chk("R3 no start before last cycle", rd_sp, 0);
    put_addr(8'h34);
    put_addr(8'h56);
    chk("R3 start on last cycle", rd_sp, 1);
    chk("R2 little-endian address", oa_sp, 24'h563412);
    chk("R3 offset for 0x00", of_sp, 0);
    chk("R11 busy with start", rdy_sp, 0);
    chk("R4 large page waits for confirm", rd_lp, 0);
    @(negedge clk);
    chk("R14 pulse one cycle", rd_sp, 0);
    finish_op(1'b0);
    chk("R11 ready on done", rdy_sp, 1);
    put_cmd(8'h01); put_addr(8'h00); put_addr(8'h02); put_addr(8'h00);
    chk("R3 start for 0x01", rd_sp, 1);
    chk("R3 offset for 0x01", of_sp, 256);
    chk("R2 address for 0x01 read", oa_sp, 24'h000200);
    chk("R13 0x01 not a read in large page", rd_lp, 0);
    finish_op(1'b0);
    put_cmd(8'h50); put_addr(8'h04); put_addr(8'h01); put_addr(8'h00);
    chk("R3 offset for 0x50", of_sp, 512);
    chk("R3 address for 0x50 read", oa_sp, 24'h000104);
    finish_op(1'b0);
    put_cmd(8'h00); put_addr(8'hAA); put_addr(8'hBB); put_addr(8'hCC);
    chk("R3 offset back to 0", of_sp, 0);
    chk("R2 address lanes", oa_sp, 24'hCCBBAA);
    finish_op(1'b0);
  endtask

  task automatic t_large_reads;
    put_cmd(8'h00);
    put_addr(8'h11); put_addr(8'h22); put_addr(8'h33); put_addr(8'h44); put_addr(8'h55);
    chk("R4 no start after address cycles", rd_lp, 0);
    put_cmd(8'h30);
    chk("R4 start on 0x30", rd_lp, 1);
    chk("R4 read address", oa_lp, 40'h5544332211);
    chk("R4 offset zero", of_lp, 0);
    chk("R13 0x30 ignored in small page", rd_sp, 0);
    finish_op(1'b0);
    put_cmd(8'h05); put_addr(8'h66); put_cmd(8'hE0);
    chk("R5 start on 0xE0", rd_lp, 1);
    chk("R5 column cleared and rewritten", oa_lp, 40'h5544330066);
    chk("R13 0xE0 ignored in small page", rd_sp, 0);
    finish_op(1'b0);
    put_cmd(8'h05); put_addr(8'h77); put_addr(8'h08); put_cmd(8'hE0);
    chk("R5 two column cycles", oa_lp, 40'h5544330877);
    finish_op(1'b0);
  endtask

  task automatic t_program;
    put_cmd(8'h80);
    put_addr(8'h01); put_addr(8'h02); put_addr(8'h03); put_addr(8'h04); put_addr(8'h05);
    put_cmd(8'h10);
    chk("R9 program start sp", pg_sp, 1);
    chk("R9 program start lp", pg_lp, 1);
    chk("R2 extra cycles ignored", oa_sp, 24'h030201);
    chk("R9 program address lp", oa_lp, 40'h0504030201);
    chk("R11 busy sp", rdy_sp, 0);
    put_cmd(8'h70);
    chk("R7 busy status", dout_sp, 8'h80);
    finish_op(1'b1);
    chk("R11 error latched", dout_sp, 8'hC1);
    put_cmd(8'hFF);
    chk("R12 reset leaves read", dout_sp, 8'h00);
    put_cmd(8'h70);
    chk("R12 reset clears error", dout_sp, 8'hC0);
  endtask

  task automatic t_erase;
    put_cmd(8'h60);
    put_addr(8'h05); put_addr(8'h00); put_addr(8'h00);
    put_cmd(8'hD0);
    chk("R10 erase start sp", er_sp, 1);
    chk("R10 erase start lp", er_lp, 1);
    chk("R10 erase row sp", oa_sp, 24'h000500);
    chk("R10 erase row lp", oa_lp, 40'h0000050000);
    chk("R14 only erase pulse", {rd_sp, pg_sp}, 0);
    chk("R11 busy on erase", rdy_lp, 0);
    put_cmd(8'hFF);
    chk("R12 reset sets ready sp", rdy_sp, 1);
    chk("R12 reset sets ready lp", rdy_lp, 1);
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b0; cle = 1'b0; ale = 1'b0; wp_n = 1'b1;
    we_strobe = 1'b0; re_strobe = 1'b0; din = 8'h00; eng_done = 1'b0; eng_fail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_status_sticky();
    t_ce_gate();
    t_unknown();
    t_read_id();
    t_small_reads();
    t_large_reads();
    t_program();
    t_erase();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule